// File: doc/BRIEF.md
# Keyboard-Style Serial Link, Device End

This block is the peripheral end of a two-wire open-collector serial link of the keyboard/mouse kind. The device generates the link clock itself, and the host may stop or take over the wires at any time. The block accepts one byte on a valid/ready handshake, frames it and shifts it out. It watches for the host holding the clock wire low. If the host does this early in a frame, the block gives up the wires and keeps the byte for a later attempt. When the host requests to send, the block clocks in a frame from the host and answers with an acknowledge bit.

The wires are modelled as two drive enables (a 1 pulls the wire low) and two raw line inputs. Each raw input passes through a two-flop synchronizer. A free-running divider sets the half-period of the link clock, and every phase of the generated clock lasts exactly `HALF_CYC` system clocks. Received bytes appear with a one-cycle valid pulse. Framing faults produce a one-cycle error pulse instead. An aborted transmission produces a one-cycle abort pulse.

The controller has five states. In `ST_IDLE` all wires are released. `ST_TX_HI` and `ST_TX_LO` are the released and pulled halves of one transmit clock. `ST_RX_LO` and `ST_RX_HI` are the pulled and released halves of one receive clock. The transitions are:
- `go_tx`: IDLE to TX_HI, at a divider tick with both lines high and a byte pending.
- `go_rx`: IDLE to RX_LO, at a tick with the clock line high and the data line low.
- `contend`: TX_HI to IDLE, when the clock line is low at the end of a high half up to the tenth clock.
- `tx_next`: TX_HI to TX_LO, and TX_LO back to TX_HI for the next bit.
- `tx_fin`: TX_LO to IDLE, after the eleventh clock.
- `rx_next`: RX_LO to RX_HI, and RX_HI back to RX_LO for the next bit.
- `rx_fin`: RX_HI to IDLE, after the eleventh clock.

Top module: `kbd_link_dev`

## Requirements
- R1: After reset both drive enables are 0, `tx_ready` is 1, and `rx_valid`, `rx_err` and `tx_abort` are 0.
- R2: A transmit frame has 11 clocks. The data wire carries, in order: a start bit of 0, data bits 0 to 7, an odd parity bit (the XOR of the eight data bits inverted), and a stop bit of 1. Every low and every high half of the generated clock lasts `HALF_CYC` system clocks.
- R3: A frame starts only while both synchronized lines are high. While the host holds the clock wire low, a pending byte is held back and the clock wire is never driven.
- R4: During transmission the data drive changes only in the middle of a clock-high half. It is stable across each falling edge and each rising edge of the generated clock.
- R5: If the clock line is low at the end of any high half of clocks 1 to 10, the block releases both wires and pulses `tx_abort` for one cycle. The byte stays pending, with `tx_ready` held at 0, and the whole frame is sent again once both lines are high.
- R6: A low clock line during the high half of the eleventh clock is ignored. The frame completes, no abort is flagged, and `tx_ready` returns to 1.
- R7: With the clock line high and the data line low in idle, the block generates 11 clocks. It samples data at the end of each high half: clocks 1 to 8 give data bits 0 to 7, LSB first. A good frame yields `rx_byte` with a one-cycle `rx_valid` pulse.
- R8: If the data line is high at the end of the tenth receive clock (the stop bit), the block pulls the data wire low for the whole eleventh clock as the acknowledge.
- R9: A received parity bit that does not make the nine bits odd gives a one-cycle `rx_err` pulse and no `rx_valid`.
- R10: A low stop bit gives no acknowledge on the eleventh clock and a one-cycle `rx_err` pulse with no `rx_valid`.
- R11: A host request to send wins over a pending transmit byte. The host frame is received first, and the pending byte is sent afterwards.
- R12: A byte is taken in a cycle with `tx_valid` and `tx_ready` both 1. `tx_ready` stays 0 from the next cycle until that byte's frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps_clk_i | input | 1 | Raw level of the clock wire |
| ps_dat_i | input | 1 | Raw level of the data wire |
| ps_clk_oe | output | 1 | 1 pulls the clock wire low |
| ps_dat_oe | output | 1 | 1 pulls the data wire low |
| tx_byte | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_byte` is offered |
| tx_ready | output | 1 | No byte pending; an offer is taken |
| rx_byte | output | 8 | Last byte received without fault |
| rx_valid | output | 1 | One-cycle pulse: `rx_byte` updated |
| rx_err | output | 1 | One-cycle pulse: received frame had a parity or stop fault |
| tx_abort | output | 1 | One-cycle pulse: transmission aborted by the host |

## Verification
The bench builds the block with `HALF_CYC` = 16. One clock phase then lasts 16 system clocks and a whole frame fits in a few hundred cycles, so many frames, aborts and host transfers fit in one short run. A half-period of 16 still leaves the two-cycle synchronizer delay and the host model's reaction well inside each phase. This makes it possible to place a host clock pull inside a chosen high half, such as the sixth or the eleventh clock, and to land host data changes cleanly between generated edges.

// File: rtl/kbd_link_pkg.sv
package kbd_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_HI,
        ST_TX_LO,
        ST_RX_LO,
        ST_RX_HI
    } link_state_e;

    // clocks per frame and index of the last clock
    localparam int FRAME_CLKS = 11;
    localparam int LAST_IDX   = FRAME_CLKS - 1;
    // highest clock index (0-based) at which host contention aborts
    localparam int GUARD_IDX  = 9;
    // data+parity bits shifted in on receive
    localparam int RX_BITS    = 9;

    function automatic logic odd_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
            end
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/kbd_tick.sv
module kbd_tick #(
    parameter int HALF_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic mid
);
    localparam int CW   = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int HALF = HALF_CYC / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == CW'(HALF_CYC - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == CW'(HALF_CYC - 1));
    assign mid  = (cnt == CW'(HALF - 1));
endmodule

// File: rtl/kbd_frame.sv
module kbd_frame
    import kbd_link_pkg::*;
(
    input  logic [7:0]         tx_data,
    output logic [10:0]        tx_frame,
    input  logic [RX_BITS-1:0] rx_bits,
    output logic [7:0]         rx_data,
    output logic               rx_par_ok
);
    // bit 0 goes first on the wire
    assign tx_frame  = {1'b1, odd_parity(tx_data), tx_data, 1'b0};
    assign rx_data   = rx_bits[7:0];
    assign rx_par_ok = ^rx_bits;
endmodule

// File: rtl/kbd_fsm.sv
module kbd_fsm
    import kbd_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               mid,
    input  logic               clk_s,
    input  logic               dat_s,
    input  logic [7:0]         tx_byte,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic [7:0]         buf_byte,
    input  logic [10:0]        tx_frame,
    output logic [RX_BITS-1:0] rx_bits,
    input  logic [7:0]         rx_data,
    input  logic               rx_par_ok,
    output logic               ps_clk_oe,
    output logic               ps_dat_oe,
    output logic [7:0]         rx_byte,
    output logic               rx_valid,
    output logic               rx_err,
    output logic               tx_abort
);
    link_state_e state, state_nx;
    logic [3:0]  idx;
    logic        pend;
    logic        drv_q;
    logic        ack;

    logic last_clk, guarded;
    logic go_tx, go_rx, contend, tx_fin, rx_fin;

    assign last_clk = (idx == 4'(LAST_IDX));
    assign guarded  = (idx <= 4'(GUARD_IDX));
    assign go_rx    = (state == ST_IDLE) && tick && clk_s && !dat_s;
    assign go_tx    = (state == ST_IDLE) && tick && clk_s && dat_s && pend;
    assign contend  = (state == ST_TX_HI) && tick && !clk_s && guarded;
    assign tx_fin   = (state == ST_TX_LO) && tick && last_clk;
    assign rx_fin   = (state == ST_RX_HI) && tick && last_clk;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go_rx)      state_nx = ST_RX_LO;
                else if (go_tx) state_nx = ST_TX_HI;
            end
            ST_TX_HI: begin
                if (contend)   state_nx = ST_IDLE;
                else if (tick) state_nx = ST_TX_LO;
            end
            ST_TX_LO: begin
                if (tx_fin)    state_nx = ST_IDLE;
                else if (tick) state_nx = ST_TX_HI;
            end
            ST_RX_LO: begin
                if (tick) state_nx = ST_RX_HI;
            end
            ST_RX_HI: begin
                if (rx_fin)    state_nx = ST_IDLE;
                else if (tick) state_nx = ST_RX_LO;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath: bit index, buffer, shift register, result pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            pend     <= 1'b0;
            buf_byte <= '0;
            rx_bits  <= '0;
            drv_q    <= 1'b0;
            ack      <= 1'b0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
            tx_abort <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
            tx_abort <= contend;

            if (tx_valid && !pend) begin
                pend     <= 1'b1;
                buf_byte <= tx_byte;
            end else if (tx_fin) begin
                pend <= 1'b0;
            end

            if (state == ST_IDLE) begin
                idx   <= '0;
                drv_q <= 1'b0;
                ack   <= 1'b0;
            end else if (tick && !last_clk &&
                         (state == ST_TX_LO || state == ST_RX_HI)) begin
                idx <= idx + 1'b1;
            end

            // new data bit mid-way through the high half
            if (state == ST_TX_HI && mid) begin
                drv_q <= ~tx_frame[idx];
            end

            if (state == ST_RX_HI && tick) begin
                if (idx < 4'(RX_BITS)) begin
                    rx_bits <= {dat_s, rx_bits[RX_BITS-1:1]};
                end
                if (idx == 4'(RX_BITS)) begin
                    ack <= dat_s;
                end
            end

            if (rx_fin) begin
                if (ack && rx_par_ok) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= rx_data;
                end else begin
                    rx_err <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        ps_clk_oe = 1'b0;
        ps_dat_oe = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_TX_HI: ps_dat_oe = drv_q;
            ST_TX_LO: begin
                ps_clk_oe = 1'b1;
                ps_dat_oe = drv_q;
            end
            ST_RX_LO: begin
                ps_clk_oe = 1'b1;
                ps_dat_oe = last_clk && ack;
            end
            ST_RX_HI: ps_dat_oe = last_clk && ack;
            default:  ;
        endcase
        tx_ready = !pend;
    end

    p_tx_start_lines_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_HI && $past(state) == ST_IDLE) |-> $past(clk_s && dat_s));

    p_dat_stable_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ps_clk_oe) && state == ST_TX_LO) |-> $stable(ps_dat_oe));

    p_dat_stable_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ps_clk_oe) && state == ST_TX_HI) |-> $stable(ps_dat_oe));

    p_abort_holds_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (!tx_ready && !ps_clk_oe && !ps_dat_oe));

    p_result_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_err));

    p_accept_drops_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/kbd_link_dev.sv
module kbd_link_dev
    import kbd_link_pkg::*;
#(
    parameter int HALF_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps_clk_i,
    input  logic       ps_dat_i,
    output logic       ps_clk_oe,
    output logic       ps_dat_oe,
    input  logic [7:0] tx_byte,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_err,
    output logic       tx_abort
);
    logic [1:0]         lines_s;
    logic               tick, mid;
    logic [7:0]         buf_byte, rx_data;
    logic [10:0]        tx_frame;
    logic [RX_BITS-1:0] rx_bits;
    logic               rx_par_ok;

    kbd_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ps_dat_i, ps_clk_i}),
        .dout (lines_s)
    );

    kbd_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .mid  (mid)
    );

    kbd_frame u_frame (
        .tx_data  (buf_byte),
        .tx_frame (tx_frame),
        .rx_bits  (rx_bits),
        .rx_data  (rx_data),
        .rx_par_ok(rx_par_ok)
    );

    kbd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mid      (mid),
        .clk_s    (lines_s[0]),
        .dat_s    (lines_s[1]),
        .tx_byte  (tx_byte),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .buf_byte (buf_byte),
        .tx_frame (tx_frame),
        .rx_bits  (rx_bits),
        .rx_data  (rx_data),
        .rx_par_ok(rx_par_ok),
        .ps_clk_oe(ps_clk_oe),
        .ps_dat_oe(ps_dat_oe),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_err   (rx_err),
        .tx_abort (tx_abort)
    );
endmodule

// File: tb/kbd_link_dev_test.sv
`timescale 1ns/1ps
module kbd_link_dev_test;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_clk_low = 1'b0;
    logic       h_dat_low = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_valid = 1'b0;
    logic       ps_clk_oe, ps_dat_oe, tx_ready, rx_valid, rx_err, tx_abort;
    logic [7:0] rx_byte;
    logic       line_clk, line_dat;

    int  vectors = 0;
    int  miscompares = 0;
    int  nbits = 0;
    int  abort_cnt = 0;
    int  clk_rises = 0;
    bit  host_tx = 1'b0;
    logic [10:0] exp_tx[$];
    logic [8:0]  exp_rx[$];

    assign line_clk = !(ps_clk_oe || h_clk_low);
    assign line_dat = !(ps_dat_oe || h_dat_low);

    always #4 clk = ~clk;

    kbd_link_dev #(.HALF_CYC(DIV)) uut (
        .clk(clk), .rst_n(rst_n),
        .ps_clk_i(line_clk), .ps_dat_i(line_dat),
        .ps_clk_oe(ps_clk_oe), .ps_dat_oe(ps_dat_oe),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err),
        .tx_abort(tx_abort)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] frame_of(input logic [7:0] b);
        logic [10:0] f;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[i+1] = b[i];
        f[9]  = ~(^b);
        f[10] = 1'b1;
        return f;
    endfunction

    // driver: offer byte, push expected frame
    task automatic send_dev(input logic [7:0] b);
        while (!tx_ready) @(negedge clk);
        exp_tx.push_back(frame_of(b));
        tx_byte  = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R12 ready after accept", tx_ready, 0);
    endtask

    task automatic wait_tx_done();
        while (exp_tx.size() != 0 || !tx_ready) @(negedge clk);
    endtask

    // host-to-device frame
    task automatic send_host(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        logic [9:0] bits;
        bits = {~bad_stop, (~(^b)) ^ bad_par, b};
        exp_rx.push_back({bad_par | bad_stop, b});
        host_tx   = 1'b1;
        h_clk_low = 1'b1;
        repeat (6*DIV) @(negedge clk);
        h_dat_low = 1'b1;
        @(negedge clk);
        h_clk_low = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(posedge ps_clk_oe);
            repeat (2) @(negedge clk);
            h_dat_low = !bits[k];
        end
        @(posedge ps_clk_oe);
        h_dat_low = 1'b0;
        repeat (4) @(negedge clk);
        if (bad_stop) chk(line_dat == 1'b1, "R10 no ack on bad stop", line_dat, 1);
        else          chk(line_dat == 1'b0, "R8 ack on eleventh clock", line_dat, 0);
        @(negedge ps_clk_oe);
        @(negedge clk);
        host_tx = 1'b0;
        repeat (DIV + 4) @(negedge clk);
        chk(exp_rx.size() == 0, "R7 host frame result reported", exp_rx.size(), 0);
    endtask

    // monitor: frames seen on the wire at each falling clock
    initial begin
        logic [10:0] cap;
        logic [10:0] e;
        cap = '0;
        forever begin
            @(posedge ps_clk_oe or posedge tx_abort);
            if (tx_abort) begin
                nbits = 0;
            end else if (!host_tx) begin
                cap[nbits] = line_dat;
                nbits++;
                if (nbits == 11) begin
                    nbits = 0;
                    if (exp_tx.size() == 0) begin
                        chk(1'b0, "R2 unexpected frame", cap, 0);
                    end else begin
                        e = exp_tx.pop_front();
                        chk(cap == e, "R2 frame content", cap, e);
                    end
                end
            end
        end
    end

    // monitor: data drive stable while clock is pulled (R4)
    initial begin
        logic d;
        forever begin
            @(posedge ps_clk_oe);
            d = ps_dat_oe;
            @(negedge ps_clk_oe);
            if (!host_tx) chk(ps_dat_oe == d, "R4 data held over clock low", ps_dat_oe, d);
        end
    end

    // monitor: low half length, aborts, clock activity
    int lo_cnt = 0;
    logic clk_oe_d = 1'b0;
    always @(negedge clk) begin
        if (ps_clk_oe) begin
            lo_cnt++;
        end else if (lo_cnt != 0) begin
            chk(lo_cnt == DIV, "R2 low half length", lo_cnt, DIV);
            lo_cnt = 0;
        end
        if (ps_clk_oe && !clk_oe_d) clk_rises++;
        clk_oe_d = ps_clk_oe;
        if (tx_abort) abort_cnt++;
    end

    // scoreboard for received bytes
    always @(negedge clk) begin
        logic [8:0] it;
        if (rx_valid || rx_err) begin
            if (exp_rx.size() == 0) begin
                chk(1'b0, "R7 unexpected result", {rx_err, rx_byte}, 0);
            end else begin
                it = exp_rx.pop_front();
                chk(rx_err == it[8], "R9 error flag", rx_err, it[8]);
                chk(rx_valid == !it[8], "R10 valid flag", rx_valid, !it[8]);
                if (!it[8]) chk(rx_byte == it[7:0], "R7 received byte", rx_byte, it[7:0]);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int a0, r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ps_clk_oe == 0 && ps_dat_oe == 0, "R1 wires released", {ps_clk_oe, ps_dat_oe}, 0);
        chk(tx_ready == 1, "R1 ready", tx_ready, 1);
        chk(rx_valid == 0 && rx_err == 0 && tx_abort == 0, "R1 pulses low",
            {rx_valid, rx_err, tx_abort}, 0);

        // R2 several patterns
        send_dev(8'hA5); wait_tx_done();
        send_dev(8'h00); wait_tx_done();
        send_dev(8'hFF); wait_tx_done();
        send_dev(8'h01); wait_tx_done();

        // R3 inhibit holds off
        h_clk_low = 1'b1;
        repeat (2*DIV) @(negedge clk);
        r0 = clk_rises;
        send_dev(8'h3C);
        repeat (25*DIV) @(negedge clk);
        chk(clk_rises == r0, "R3 no clocks while inhibited", clk_rises, r0);
        chk(tx_ready == 0, "R3 byte still pending", tx_ready, 0);
        h_clk_low = 1'b0;
        wait_tx_done();

        // R5 early contention in sixth clock
        a0 = abort_cnt;
        send_dev(8'h5A);
        wait (nbits == 5);
        @(negedge ps_clk_oe);
        repeat (3) @(negedge clk);
        h_clk_low = 1'b1;
        repeat (2*DIV) @(negedge clk);
        chk(abort_cnt == a0 + 1, "R5 abort flagged", abort_cnt, a0 + 1);
        chk(ps_clk_oe == 0 && ps_dat_oe == 0, "R5 wires released", {ps_clk_oe, ps_dat_oe}, 0);
        chk(tx_ready == 0, "R5 byte retained", tx_ready, 0);
        repeat (10*DIV) @(negedge clk);
        chk(ps_clk_oe == 0, "R5 no drive while held", ps_clk_oe, 0);
        h_clk_low = 1'b0;
        wait_tx_done();

        // R6 late contention in eleventh clock
        a0 = abort_cnt;
        send_dev(8'hC3);
        wait (nbits == 10);
        @(negedge ps_clk_oe);
        repeat (3) @(negedge clk);
        h_clk_low = 1'b1;
        wait_tx_done();
        repeat (4) @(negedge clk);
        chk(abort_cnt == a0, "R6 no abort after tenth clock", abort_cnt, a0);
        chk(tx_ready == 1, "R6 frame completed", tx_ready, 1);
        h_clk_low = 1'b0;
        repeat (2*DIV) @(negedge clk);

        // R7/R8 host frames
        send_host(8'h5A, 0, 0);
        send_host(8'h00, 0, 0);
        send_host(8'hFF, 0, 0);
        // R9 parity fault, R10 stop fault
        send_host(8'h81, 1, 0);
        send_host(8'h42, 0, 1);

        // R11 request to send beats a pending byte
        h_clk_low = 1'b1;
        repeat (DIV) @(negedge clk);
        send_dev(8'h96);
        send_host(8'h24, 0, 0);
        chk(exp_tx.size() == 1, "R11 pending byte deferred", exp_tx.size(), 1);
        wait_tx_done();

        repeat (4*DIV) @(negedge clk);
        chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R7 scoreboard drained",
            exp_tx.size() + exp_rx.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule